// File: doc/BRIEF.md
# Serial Shift Engine with Collision and Overrun Flags

This block is a serial peripheral engine that can act either as the clocking side (master) or as the selected side (slave) of a four-wire SPI link. Software reaches it through a small register port with three registers. The data register loads the outgoing character and returns the received one. The mode register holds an enable bit, the master/slave choice and a character-length code. The status register holds three sticky flags, each cleared by writing a 1 to its bit: transfer complete (interrupt request), overrun, and collision. It also has a read-only busy bit.

As master, the engine produces its serial clock from an external per-cycle enable, so the bit rate is set by whoever drives that enable. It shifts the character out starting at the most significant bit of the configured length. It samples the return line on the rising clock half and finishes after the last bit. As slave, it shifts on edges of the incoming clock for as long as the select line is held low, and it marks completion when the select line is released. A second master pulling the select line low while this one is enabled is treated as a collision and stops the transfer.

Top module: `spi_eng`

## Requirements
- R1: After reset, the irq, sck_out, mosi_out and miso_out ports are 0. Reading the mode register (address 1) and the status register (address 2) returns 0.
- R2: Mode register bit 7 is enable, bit 6 selects master mode and bits [2:0] hold the length code N. In enabled master mode, when idle, a write to the data register (address 0) starts a transfer. mosi_out presents bit N-1 of the written value at once, and the engine sends N bits from the top bit down. sck_out idles low and gives one high pulse per bit. Each bit takes two bit_tick cycles: the first raises sck_out and samples miso_in, the second lowers it.
- R3: A master transfer sets the status irq flag (bit 0) and drives the irq port high on the clock edge that ends the last low half of sck_out. With bit_tick held high, that is 2·N edges after the write edge. A data register read then returns the received bits in bits [N-1:0], with zeros above them.
- R4: A length code of 0 selects a full 8-bit character.
- R5: A data register write while a transfer is in progress sets the overrun flag (status bit 1). The written value is discarded, and the character in flight and the received result are left unchanged.
- R6: Writing 1 to status bit 1 clears the overrun flag. Writing 0 there leaves it set, and the write does not disturb the other flags.
- R7: While enabled in master mode, a low ss_n_in sets the collision flag (status bit 2) on the next edge. It also aborts any transfer, returns sck_out low, clears busy (status bit 3) and raises no interrupt.
- R8: Writing 1 to status bit 2 clears the collision flag. While the fault condition is still present, the flag stays set.
- R9: In enabled slave mode, a low ss_n_in starts a transfer. mosi_in is sampled on each rising sck_in edge. Each falling edge moves to the next lower bit, and miso_out presents the loaded character's bits from bit N-1 down. The irq flag stays clear until ss_n_in returns high and is set on that edge. The data register then holds the received character.
- R10: Writing 1 to status bit 0 clears the irq flag, and the irq port falls with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 mode, 2 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| bit_tick | input | 1 | Master serial clock enable, one half bit per pulse |
| sck_in | input | 1 | Serial clock from the remote master (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_in | input | 1 | Serial data in while in slave mode |
| mosi_out | output | 1 | Serial data out while in master mode |
| miso_in | input | 1 | Serial data in while in master mode |
| miso_out | output | 1 | Serial data out while in slave mode |
| ss_n_in | input | 1 | Active-low select; start/stop in slave mode, collision detect in master mode |
| irq | output | 1 | Pending transfer-complete request |

## Verification
The bench builds the engine with the default DATA_W of 8, which gives a 3-bit length code. A single table can therefore walk every code from 1 to 7 plus the zero code that stands for a full byte. In master mode it loops an inverted copy of mosi_out back into miso_in, so every received bit shows that the sampling happened and where it landed. Directed cases cover an overrun write in mid-transfer, a collision with the select line held low across a clear attempt, and slave transfers of full and partial length.

// File: rtl/spi_eng_pkg.sv
// Shared constants and types for the serial shift engine.
// Assumes a 2-bit register address space.
package spi_eng_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Status register bit positions
    localparam int ST_IRQ  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_COL  = 2;
    localparam int ST_BUSY = 3;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MRUN = 2'd1,
        ENG_SRUN = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_eng_regs.sv
// Register file: mode register, sticky status flags with write-one-to-clear,
// read multiplexer, and the load/overrun decode of data register writes.
// Assumes DATA_W >= CNT_W + 2 so that the mode bits do not overlap.
module spi_eng_regs #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic              fault,
    input  logic [DATA_W-1:0] rx_word,
    output logic              en,
    output logic              mst,
    output logic [CNT_W-1:0]  numbits,
    output logic              data_load,
    output logic              irq_flag,
    output logic              ovr_flag,
    output logic              col_flag
);
    import spi_eng_pkg::*;

    localparam logic [DATA_W-1:0] MODE_MASK =
        (DATA_W'(1) << (DATA_W-1)) | (DATA_W'(1) << (DATA_W-2)) | DATA_W'((1 << CNT_W) - 1);

    logic [DATA_W-1:0] mode_q;
    logic              data_wr;
    logic              stat_wr;
    logic              ovr_set;

    assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
    assign stat_wr   = reg_wr && (reg_addr == ADDR_STAT);
    assign ovr_set   = data_wr && busy;
    assign data_load = data_wr && en && !busy;

    assign en      = mode_q[DATA_W-1];
    assign mst     = mode_q[DATA_W-2];
    assign numbits = mode_q[CNT_W-1:0];

    // Mode register storage, keeping only the defined bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (reg_wr && (reg_addr == ADDR_MODE))
            mode_q <= reg_wdata & MODE_MASK;
    end

    // Sticky status flags: a set in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            ovr_flag <= 1'b0;
            col_flag <= 1'b0;
        end else begin
            irq_flag <= (irq_flag && !(stat_wr && reg_wdata[ST_IRQ])) || xfer_done;
            ovr_flag <= (ovr_flag && !(stat_wr && reg_wdata[ST_OVR])) || ovr_set;
            col_flag <= (col_flag && !(stat_wr && reg_wdata[ST_COL])) || fault;
        end
    end

    // Read multiplexer for the addressed register
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_DATA: reg_rdata = rx_word;
            ADDR_MODE: reg_rdata = mode_q;
            ADDR_STAT: begin
                reg_rdata[ST_IRQ]  = irq_flag;
                reg_rdata[ST_OVR]  = ovr_flag;
                reg_rdata[ST_COL]  = col_flag;
                reg_rdata[ST_BUSY] = busy;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_eng_shreg.sv
// Character register: parallel load from software, single-bit replace at
// the current index when a sample arrives, and right-justified readback
// masked to the active character length.
// Assumes idx and top are both below DATA_W.
module spi_eng_shreg #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sample_en,
    input  logic              sample_bit,
    input  logic [CNT_W-1:0]  idx,
    input  logic [CNT_W-1:0]  top,
    output logic              bit_out,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] keep;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic bit_q;

        // One storage bit: load wins, else overwrite when this bit is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (load)
                bit_q <= load_data[i];
            else if (sample_en && (idx == CNT_W'(i)))
                bit_q <= sample_bit;
        end

        assign sh_q[i] = bit_q;
        assign keep[i] = (CNT_W'(i) <= top);
    end

    assign bit_out = sh_q[idx];
    assign rx_word = sh_q & keep;
endmodule

// File: rtl/spi_eng_ctrl.sv
// Transfer sequencer for both roles. As master it toggles sck on bit_tick,
// samples on the high half and steps down on the low half. As slave it
// follows sck_in edges while ss_n_in is low. It also detects the collision.
// Assumes sck_in, ss_n_in and mosi_in are already synchronous to clk.
module spi_eng_ctrl #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mst,
    input  logic [CNT_W-1:0] top,
    input  logic             load,
    input  logic             bit_tick,
    input  logic             sck_in,
    input  logic             ss_n_in,
    output logic             busy,
    output logic             xfer_done,
    output logic             fault,
    output logic             sample_en,
    output logic             sck_out,
    output logic [CNT_W-1:0] idx
);
    import spi_eng_pkg::*;

    eng_state_e       state_q, state_d;
    logic             sck_q, sck_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             sck_in_q;
    logic             sck_rise, sck_fall;

    assign fault    = en && mst && !ss_n_in;
    assign sck_rise = sck_in && !sck_in_q;
    assign sck_fall = !sck_in && sck_in_q;
    assign busy     = (state_q != ENG_IDLE);
    assign sck_out  = sck_q;
    assign idx      = idx_q;

    // Next-state, clock and bit index decisions
    always_comb begin
        state_d   = state_q;
        sck_d     = sck_q;
        idx_d     = idx_q;
        xfer_done = 1'b0;
        sample_en = 1'b0;
        case (state_q)
            ENG_IDLE: begin
                idx_d = top;
                sck_d = 1'b0;
                if (en && !mst && !ss_n_in)
                    state_d = ENG_SRUN;
                else if (load && en && mst && !fault)
                    state_d = ENG_MRUN;
            end
            ENG_MRUN: begin
                if (fault || !en || !mst) begin
                    state_d = ENG_IDLE;
                    sck_d   = 1'b0;
                end else if (bit_tick) begin
                    if (!sck_q) begin
                        sck_d     = 1'b1;
                        sample_en = 1'b1;
                    end else begin
                        sck_d = 1'b0;
                        if (idx_q == '0) begin
                            state_d   = ENG_IDLE;
                            xfer_done = 1'b1;
                        end else begin
                            idx_d = idx_q - 1'b1;
                        end
                    end
                end
            end
            ENG_SRUN: begin
                if (ss_n_in || !en || mst) begin
                    state_d   = ENG_IDLE;
                    xfer_done = ss_n_in && en && !mst;
                end else begin
                    if (sck_rise)
                        sample_en = 1'b1;
                    if (sck_fall)
                        idx_d = (idx_q == '0) ? top : idx_q - 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    // Sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ENG_IDLE;
            sck_q    <= 1'b0;
            idx_q    <= '0;
            sck_in_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            sck_q    <= sck_d;
            idx_q    <= idx_d;
            sck_in_q <= sck_in;
        end
    end
endmodule

// File: rtl/spi_eng.sv
// Top level of the serial shift engine: joins the register file, the
// character register and the sequencer, and gates the data pins by role.
// Assumes all pin inputs are synchronous to clk.
module spi_eng #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bit_tick,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              mosi_in,
    output logic              mosi_out,
    input  logic              miso_in,
    output logic              miso_out,
    input  logic              ss_n_in,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              en, mst, busy, xfer_done, fault, sample_en, data_load;
    logic              irq_flag, ovr_flag, col_flag, bit_out, sample_bit;
    logic [CNT_W-1:0]  numbits, top_idx, idx;
    logic [DATA_W-1:0] rx_word;

    assign top_idx    = (numbits == '0) ? CNT_W'(DATA_W - 1) : numbits - 1'b1;
    assign sample_bit = mst ? miso_in : mosi_in;
    assign mosi_out   = (mst && busy) ? bit_out : 1'b0;
    assign miso_out   = (!mst && busy) ? bit_out : 1'b0;
    assign irq        = irq_flag;

    spi_eng_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .xfer_done(xfer_done), .fault(fault), .rx_word(rx_word), .en(en),
        .mst(mst), .numbits(numbits), .data_load(data_load),
        .irq_flag(irq_flag), .ovr_flag(ovr_flag), .col_flag(col_flag)
    );

    spi_eng_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(data_load), .load_data(reg_wdata),
        .sample_en(sample_en), .sample_bit(sample_bit), .idx(idx),
        .top(top_idx), .bit_out(bit_out), .rx_word(rx_word)
    );

    spi_eng_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .top(top_idx),
        .load(data_load), .bit_tick(bit_tick), .sck_in(sck_in),
        .ss_n_in(ss_n_in), .busy(busy), .xfer_done(xfer_done), .fault(fault),
        .sample_en(sample_en), .sck_out(sck_out), .idx(idx)
    );
endmodule

// File: rtl/spi_eng_chk.sv
// Property checker for the serial shift engine, bound to the top module.
// Assumes it sees the mode bits and flags of the register file.
module spi_eng_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              busy,
    input logic              sck_out,
    input logic              ss_n_in,
    input logic              en,
    input logic              mst,
    input logic              irq,
    input logic              ovr,
    input logic              col
);
    import spi_eng_pkg::*;

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out);

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy));

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DATA && busy) |=> ovr);

    // R5
    ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DATA && !busy && !ovr) |=> !ovr);

    // R6
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_OVR]) |=> !ovr);

    // R7
    col_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mst && !ss_n_in) |=> (col && !busy && !sck_out));

    // R8
    col_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_COL] && !(en && mst && !ss_n_in))
        |=> !col);

    // R10
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_IRQ] && !busy) |=> !irq);
endmodule

bind spi_eng spi_eng_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .sck_out(sck_out), .ss_n_in(ss_n_in),
    .en(en), .mst(mst), .irq(irq_flag), .ovr(ovr_flag), .col(col_flag)
);

// File: tb/spi_eng_tb.sv
`timescale 1ns/1ps
module spi_eng_tb;
    localparam int DW = 8;

    // {length code[2:0], tx byte[7:0]} for master transfers
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 8'hA5}, {3'd1, 8'h01}, {3'd2, 8'h02}, {3'd3, 8'hF5},
        {3'd4, 8'h0C}, {3'd5, 8'h13}, {3'd6, 8'h2D}, {3'd7, 8'hDA}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bit_tick = 1'b1;
    logic          sck_in = 1'b0;
    logic          sck_out;
    logic          mosi_in = 1'b0;
    logic          mosi_out;
    logic          miso_in;
    logic          miso_out;
    logic          ss_n_in = 1'b1;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign miso_in = ~mosi_out;

    spi_eng #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
        .sck_in(sck_in), .sck_out(sck_out), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .miso_in(miso_in), .miso_out(miso_out),
        .ss_n_in(ss_n_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_irq(output int cnt, output int rises);
        logic prev;
        cnt = 0; rises = 0; prev = sck_out;
        while (!irq && cnt < 200) begin
            @(posedge clk); @(negedge clk);
            cnt++;
            if (sck_out && !prev) rises++;
            prev = sck_out;
        end
    endtask

    task automatic slave_xfer(input logic [2:0] nb, input logic [7:0] tx, input logic [7:0] pat);
        int nbe;
        logic [7:0] got, mask, d;
        nbe  = (nb == 3'd0) ? 8 : int'(nb);
        mask = 8'((9'd1 << nbe) - 9'd1);
        got  = '0;
        wr(2'd1, 8'h80 | {5'd0, nb});
        wr(2'd0, tx);
        ss_n_in = 1'b0;
        @(posedge clk); @(negedge clk);
        for (int i = nbe - 1; i >= 0; i--) begin
            mosi_in = pat[i];
            sck_in  = 1'b1;
            got[i]  = miso_out;
            @(posedge clk); @(negedge clk);
            sck_in = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        check("R9 slave irq before release", 32'(irq), 32'd0);
        ss_n_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 slave irq on release", 32'(irq), 32'd1);
        rd(2'd0, d);
        check("R9 slave received", 32'(d), 32'(pat & mask));
        check("R9 slave miso bits", 32'(got), 32'(tx & mask));
        wr(2'd2, 8'h01);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int cnt, rises;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 sck_out", 32'(sck_out), 32'd0);
        check("R1 mosi/miso", 32'({mosi_out, miso_out}), 32'd0);
        rd(2'd1, d); check("R1 mode", 32'(d), 32'd0);
        rd(2'd2, d); check("R1 status", 32'(d), 32'd0);

        // Table walk over every length code in master mode
        for (int v = 0; v < 8; v++) begin
            logic [2:0] nb;
            logic [7:0] tx, mask;
            int nbe;
            nb   = VEC[v][10:8];
            tx   = VEC[v][7:0];
            nbe  = (nb == 3'd0) ? 8 : int'(nb);
            mask = 8'((9'd1 << nbe) - 9'd1);
            wr(2'd1, 8'hC0 | {5'd0, nb});
            wr(2'd0, tx);
            check("R2 first mosi bit", 32'(mosi_out), 32'(tx[nbe-1]));
            wait_irq(cnt, rises);
            check("R3 cycles to irq", 32'(cnt), 32'(2 * nbe));
            check("R2 sck pulses", 32'(rises), 32'(nbe));
            rd(2'd0, d);
            if (nb == 3'd0)
                check("R4 full byte received", 32'(d), 32'(~tx & mask));
            else
                check("R3 received word", 32'(d), 32'(~tx & mask));
            wr(2'd2, 8'h01);
            check("R10 irq cleared", 32'(irq), 32'd0);
        end

        // Overrun during a full-byte master transfer
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'h3C);
        @(posedge clk); @(negedge clk);
        wr(2'd0, 8'hFF);
        rd(2'd2, d); check("R5 overrun flagged while busy", 32'(d), 32'h0A);
        wait_irq(cnt, rises);
        rd(2'd0, d); check("R5 overrun write discarded", 32'(d), 32'hC3);
        wr(2'd2, 8'h00);
        rd(2'd2, d); check("R6 zero write keeps flags", 32'(d), 32'h03);
        wr(2'd2, 8'h02);
        rd(2'd2, d); check("R6 overrun cleared only", 32'(d), 32'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, d); check("R10 status clear", 32'(d), 32'h00);

        // Collision while a master transfer runs
        wr(2'd0, 8'h81);
        repeat (3) begin @(posedge clk); @(negedge clk); end
        ss_n_in = 1'b0;
        @(posedge clk); @(negedge clk);
        rd(2'd2, d); check("R7 collision set and aborted", 32'(d), 32'h04);
        check("R7 sck idle after abort", 32'(sck_out), 32'd0);
        repeat (20) begin @(posedge clk); @(negedge clk); end
        check("R7 no irq after abort", 32'(irq), 32'd0);
        wr(2'd2, 8'h04);
        rd(2'd2, d); check("R8 collision persists while ss low", 32'(d), 32'h04);
        ss_n_in = 1'b1;
        wr(2'd2, 8'h04);
        rd(2'd2, d); check("R8 collision cleared", 32'(d), 32'h00);

        // Slave transfers, full byte and a 4-bit character
        slave_xfer(3'd0, 8'hA5, 8'h6B);
        slave_xfer(3'd4, 8'h09, 8'h0C);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule